// File: doc/BRIEF.md
# LCD Column Row Loader

This block collects one row of display data for an 80-column dot-matrix LCD column driver and turns it into a two-bit drive-level select for each column. A row enters in one of two modes. In serial mode, one bit arrives per data strobe on the top data lane. In parallel mode, a four-bit group arrives per strobe, and each lane feeds every fourth column. An address counter chooses where each write lands in a first row latch. A falling edge on the row-load strobe copies the first latch into a second latch, and the second latch sets the column outputs.

Several loaders can be chained so that they share one data bus. A loader accepts strobes only while its active-low enable input is low. It drives its own active-low enable output low once its row is full, and that output enables the next loader in the chain. The row-load strobe rewinds the address counter and raises the enable output again. Each column's select code is set by three things: its latched bit, the alternation input that swaps between the two voltage pairs, and a display-off input that blanks every column.

The data strobe and the row-load strobe are sampled on the block clock. Each event is their falling edge as seen from one clock to the next.

Top module: `lcdcol_loader`

## Requirements
- R1: After reset, the enable output is high, both row latches hold all zeros and the address counter is at its first position. With alternation and display-off low, every column code is 01.
- R2: In serial mode (par_mode=0), each accepted falling edge of cp_i writes din[3] into the next column in ascending order, starting with column 1 (drive_sel bits 1:0). din[2:0] have no effect.
- R3: In parallel mode (par_mode=1), accepted strobe number g (counted from 0) writes din[0] to column 4g+1, din[1] to 4g+2, din[2] to 4g+3 and din[3] to 4g+4. Column n occupies drive_sel bits 2n-1:2n-2.
- R4: While cen_in_n is high, cp_i falling edges write nothing and do not advance the address.
- R5: One clock after the 80th serial write, or after the 20th parallel write, cen_out_n goes low. Further cp_i falling edges are then ignored until a row load.
- R6: A falling edge of load_i copies the first latch into the second latch, rewinds the address to the first position and raises cen_out_n, all on the same clock. The first latch keeps its contents.
- R7: If load_i and cp_i fall on the same clock, the load takes place and the data write is dropped.
- R8: Each column's code is 00 (V1) when the column is selected with alt_m=0, 01 (V3) when unselected with alt_m=0, 11 (VEE) when selected with alt_m=1, and 10 (V4) when unselected with alt_m=1. When disp_off=1, every column is treated as unselected.
- R9: Between row loads, the column codes depend only on alt_m and disp_off. Writes into the first latch do not reach the outputs.
- R10: Only a falling edge of cp_i writes. A strobe held low for many clocks writes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; cp_i and load_i are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cp_i | input | 1 | Data strobe; a write happens on its falling edge |
| load_i | input | 1 | Row-load strobe; acts on its falling edge |
| cen_in_n | input | 1 | Active-low chain enable from the previous loader |
| par_mode | input | 1 | 0 = serial entry on din[3], 1 = four-lane parallel entry |
| din | input | 4 | Data lanes; din[3] is the serial lane |
| alt_m | input | 1 | Alternation select between the two voltage pairs |
| disp_off | input | 1 | Forces every column to its unselected level |
| cen_out_n | output | 1 | Active-low chain enable to the next loader; low when the row is full |
| drive_sel | output | 160 | Two-bit level code per column; column n at bits 2n-1:2n-2 |

## Verification
An address counter that is off by one shows up as a shifted bit pattern on drive_sel right after the next row load. It also moves the fall of cen_out_n by one clock, and that is visible on the cycle after the last write. A wrong lane or group decode moves or duplicates bits across columns, and this too appears at the first load after it. A first latch that leaks into the outputs, or a load that fails to rewind, changes drive_sel or cen_out_n within one clock. Because the bench compares every column code and the enable on every cycle, each of these faults is reported as soon as it can be seen at the ports.

// File: rtl/lcdcol_pkg.sv
package lcdcol_pkg;

  // Two-bit level select carried per column
  typedef enum logic [1:0] {
    LV_V1  = 2'b00,
    LV_V3  = 2'b01,
    LV_V4  = 2'b10,
    LV_VEE = 2'b11
  } drv_lvl_e;

  // Level for one column from its bit, alternation phase and blanking
  function automatic drv_lvl_e pick_level(input logic bit_on, input logic alt,
                                          input logic blank);
    logic sel;
    sel = bit_on & ~blank;
    if (!alt) return sel ? LV_V1 : LV_V3;
    else      return sel ? LV_VEE : LV_V4;
  endfunction

  // Number of writes that fill a row in the given mode
  function automatic int row_writes(input logic par, input int ncol, input int lanes);
    return par ? (ncol / lanes) : ncol;
  endfunction

endpackage

// File: rtl/lcdcol_fall.sv
module lcdcol_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/lcdcol_addr.sv
module lcdcol_addr #(
  parameter int NUM_COL = 80,
  parameter int LANES   = 4,
  localparam int NUM_GRP = NUM_COL / LANES,
  localparam int ADDR_W  = $clog2(NUM_COL + 1),
  localparam int LANE_W  = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_mode,
  input  logic               step,
  input  logic               clear,
  output logic [ADDR_W-1:0]  cnt_o,
  output logic               full_o,
  output logic [NUM_COL-1:0] wmask_o
);
  import lcdcol_pkg::*;

  localparam logic [ADDR_W-1:0] LIM_SER = ADDR_W'(row_writes(1'b0, NUM_COL, LANES));
  localparam logic [ADDR_W-1:0] LIM_PAR = ADDR_W'(row_writes(1'b1, NUM_COL, LANES));

  logic [ADDR_W-1:0]  cnt_q;
  logic [ADDR_W-1:0]  limit;
  logic [ADDR_W-1:0]  grp_idx;
  logic [LANE_W-1:0]  lane_idx;
  logic [NUM_GRP-1:0] grp_sel;
  logic [LANES-1:0]   lane_en;
  logic               adv;

  assign limit  = par_mode ? LIM_PAR : LIM_SER;
  assign full_o = (cnt_q >= limit);
  assign adv    = step & ~full_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  // Serial: counter names a column; parallel: counter names a group
  assign grp_idx  = par_mode ? cnt_q : (cnt_q >> LANE_W);
  assign lane_idx = cnt_q[LANE_W-1:0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_sel[g] = (grp_idx == ADDR_W'(g));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = par_mode | (lane_idx == LANE_W'(l));
  end

  for (genvar c = 0; c < NUM_COL; c++) begin : g_col
    assign wmask_o[c] = adv & grp_sel[c / LANES] & lane_en[c % LANES];
  end

  assign cnt_o = cnt_q;

  AST_SER_ONE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && adv) |-> ($countones(wmask_o) == 1));                    // R2
  AST_PAR_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && adv) |-> ($countones(wmask_o) == LANES));                 // R3
  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));                   // R5
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (wmask_o == '0));                                           // R5
endmodule

// File: rtl/lcdcol_rowlatch.sv
module lcdcol_rowlatch #(
  parameter int NUM_COL = 80,
  parameter int LANES   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_mode,
  input  logic [LANES-1:0]   din,
  input  logic [NUM_COL-1:0] wmask,
  input  logic               xfer,
  output logic [NUM_COL-1:0] first_o,
  output logic [NUM_COL-1:0] second_o
);
  logic [NUM_COL-1:0] wbit;
  logic [NUM_COL-1:0] first_q;
  logic [NUM_COL-1:0] second_q;

  for (genvar c = 0; c < NUM_COL; c++) begin : g_wbit
    assign wbit[c] = par_mode ? din[c % LANES] : din[LANES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
    end else begin
      for (int c = 0; c < NUM_COL; c++)
        if (wmask[c]) first_q[c] <= wbit[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    second_q <= '0;
    else if (xfer) second_q <= first_q;
  end

  assign first_o  = first_q;
  assign second_o = second_q;

  AST_SECOND_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(second_q));                                          // R9
  AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (second_q == $past(first_q)));                                // R6
  AST_FIRST_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask == '0) |=> $stable(first_q));                                   // R4
endmodule

// File: rtl/lcdcol_drive.sv
module lcdcol_drive #(
  parameter int NUM_COL = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_COL-1:0]   row,
  input  logic                 alt_m,
  input  logic                 disp_off,
  output logic [2*NUM_COL-1:0] sel_o
);
  import lcdcol_pkg::*;

  for (genvar c = 0; c < NUM_COL; c++) begin : g_col
    assign sel_o[2*c +: 2] = pick_level(row[c], alt_m, disp_off);

    AST_OFF_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      disp_off |-> (sel_o[2*c+1] != sel_o[2*c]));                          // R8
    AST_PAIR_FOLLOWS_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[2*c+1] == alt_m);                                              // R8
  end
endmodule

// File: rtl/lcdcol_loader.sv
module lcdcol_loader #(
  parameter int NUM_COL = 80,
  parameter int LANES   = 4,
  localparam int ADDR_W = $clog2(NUM_COL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cp_i,
  input  logic                 load_i,
  input  logic                 cen_in_n,
  input  logic                 par_mode,
  input  logic [LANES-1:0]     din,
  input  logic                 alt_m,
  input  logic                 disp_off,
  output logic                 cen_out_n,
  output logic [2*NUM_COL-1:0] drive_sel
);
  logic               cp_fall;
  logic               load_fall;
  logic               step;
  logic               full;
  logic [ADDR_W-1:0]  cnt;
  logic [NUM_COL-1:0] wmask;
  logic [NUM_COL-1:0] row_first;
  logic [NUM_COL-1:0] row_second;

  lcdcol_fall u_cp_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(cp_i), .fall_o(cp_fall)
  );

  lcdcol_fall u_ld_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(load_i), .fall_o(load_fall)
  );

  // Row load outranks a data strobe on the same clock
  assign step = cp_fall & ~cen_in_n & ~load_fall;

  lcdcol_addr #(.NUM_COL(NUM_COL), .LANES(LANES)) u_addr (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .step(step),
    .clear(load_fall), .cnt_o(cnt), .full_o(full), .wmask_o(wmask)
  );

  lcdcol_rowlatch #(.NUM_COL(NUM_COL), .LANES(LANES)) u_latch (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .din(din), .wmask(wmask),
    .xfer(load_fall), .first_o(row_first), .second_o(row_second)
  );

  lcdcol_drive #(.NUM_COL(NUM_COL)) u_drive (
    .clk(clk), .rst_n(rst_n), .row(row_second), .alt_m(alt_m),
    .disp_off(disp_off), .sel_o(drive_sel)
  );

  assign cen_out_n = ~full;

  AST_LOAD_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> (cen_out_n && cnt == '0));                               // R6
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cen_in_n |=> $stable(row_first));                                      // R4
  AST_LOAD_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && cp_fall) |=> $stable(row_first));                        // R7
  AST_HELD_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_i && !$fell(cp_i)) |-> (wmask == '0));                            // R10
endmodule

// File: tb/lcdcol_loader_bench.sv
module lcdcol_loader_bench;
  localparam int NCOL = 80;
  localparam int NL   = 4;
  localparam int NGRP = NCOL / NL;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cp = 1'b1, load = 1'b1, cen_in_n = 1'b0, par = 1'b0;
  logic [NL-1:0] din = '0;
  logic alt = 1'b0, off = 1'b0;
  logic cen_out_n;
  logic [2*NCOL-1:0] drive_sel;

  lcdcol_loader u_lcdcol_loader (
    .clk(clk), .rst_n(rst_n), .cp_i(cp), .load_i(load), .cen_in_n(cen_in_n),
    .par_mode(par), .din(din), .alt_m(alt), .disp_off(off),
    .cen_out_n(cen_out_n), .drive_sel(drive_sel)
  );

  int total = 0, bad = 0;
  string cur_req = "R1";

  // Behavioural reference state
  logic [NCOL-1:0] m_l1, m_l2;
  int m_cnt;
  logic m_pcp, m_pld;

  function automatic logic [1:0] exp_code(input logic b, input logic a, input logic o);
    case ({a, o, b})
      3'b001:  return 2'b00;
      3'b000:  return 2'b01;
      3'b101:  return 2'b11;
      3'b100:  return 2'b10;
      3'b010, 3'b011: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [2*NCOL-1:0] exp_row(input logic [NCOL-1:0] r, input logic a,
                                                input logic o);
    logic [2*NCOL-1:0] v;
    for (int c = 0; c < NCOL; c++) v[2*c +: 2] = exp_code(r[c], a, o);
    return v;
  endfunction

  function automatic logic ser_pat(input int k);
    return ((k * 7 + k / 3) % 3) == 0;
  endfunction

  function automatic logic [3:0] nib(input int g);
    return 4'((g * 5 + 3) % 16);
  endfunction

  task automatic chk(input string req, input logic [2*NCOL-1:0] act,
                     input logic [2*NCOL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_l1 = '0; m_l2 = '0; m_cnt = 0; m_pcp = 1'b0; m_pld = 1'b0;
    end else begin
      int lim;
      logic cpf, ldf;
      lim = par ? NGRP : NCOL;
      cpf = m_pcp && !cp;
      ldf = m_pld && !load;
      if (ldf) begin
        m_l2 = m_l1;
        m_cnt = 0;
      end else if (cpf && !cen_in_n && m_cnt < lim) begin
        if (par) for (int l = 0; l < NL; l++) m_l1[NL*m_cnt + l] = din[l];
        else     m_l1[m_cnt] = din[NL-1];
        m_cnt++;
      end
      m_pcp = cp;
      m_pld = load;
    end
    #3;
    if (rst_n) begin
      chk({cur_req, " enable"}, {{(2*NCOL-1){1'b0}}, cen_out_n},
          {{(2*NCOL-1){1'b0}}, (m_cnt < (par ? NGRP : NCOL))});
      chk({cur_req, " columns"}, drive_sel, exp_row(m_l2, alt, off));
    end
  end

  task automatic pulse_cp(input logic [3:0] d);
    @(negedge clk); din = d; cp = 1'b0;
    @(negedge clk); cp = 1'b1;
  endtask

  task automatic pulse_ld;
    @(negedge clk); load = 1'b0;
    @(negedge clk); load = 1'b1;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [NCOL-1:0] ser_row, par_row, r9_row;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 enable", {159'b0, cen_out_n}, {159'b0, 1'b1});
    chk("R1 columns", drive_sel, {NCOL{2'b01}});

    // R2 serial row with junk on the unused lanes
    cur_req = "R2";
    for (int k = 0; k < NCOL; k++) begin
      ser_row[k] = ser_pat(k);
      pulse_cp({ser_pat(k), 3'(k) ^ 3'b101});
    end
    #1;
    chk("R5 serial full", {159'b0, cen_out_n}, {159'b0, 1'b0});
    cur_req = "R5";
    for (int k = 0; k < 3; k++) pulse_cp(4'hF);
    cur_req = "R6";
    pulse_ld();
    #1;
    chk("R2 serial row", drive_sel, exp_row(ser_row, 1'b0, 1'b0));
    chk("R6 rearm", {159'b0, cen_out_n}, {159'b0, 1'b1});

    // R8 level table sweep
    cur_req = "R8";
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); alt = s[0]; off = s[1];
      @(negedge clk); #1;
      chk("R8 levels", drive_sel, exp_row(ser_row, s[0], s[1]));
    end
    @(negedge clk); alt = 1'b0; off = 1'b0;

    // R3 parallel row, R4 disabled strobes in the middle
    par = 1'b1;
    cur_req = "R3";
    for (int g = 0; g < NGRP; g++) begin
      if (g == 10) begin
        cur_req = "R4";
        @(negedge clk); cen_in_n = 1'b1;
        for (int k = 0; k < 3; k++) pulse_cp(4'hF);
        @(negedge clk); cen_in_n = 1'b0;
        cur_req = "R3";
      end
      for (int l = 0; l < NL; l++) par_row[NL*g + l] = nib(g)[l];
      pulse_cp(nib(g));
    end
    #1;
    chk("R5 parallel full", {159'b0, cen_out_n}, {159'b0, 1'b0});
    pulse_ld();
    #1;
    chk("R3 R4 parallel row", drive_sel, exp_row(par_row, 1'b0, 1'b0));

    // R9 writes without a load leave the outputs alone
    cur_req = "R9";
    r9_row = par_row;
    for (int g = 0; g < 4; g++) begin
      logic [3:0] v;
      v = 4'(g + 6);
      for (int l = 0; l < NL; l++) r9_row[NL*g + l] = v[l];
      pulse_cp(v);
    end
    #1;
    chk("R9 outputs held", drive_sel, exp_row(par_row, 1'b0, 1'b0));

    // R10 strobe held low writes once
    cur_req = "R10";
    @(negedge clk); din = 4'b1010; cp = 1'b0;
    repeat (5) @(negedge clk);
    cp = 1'b1;
    for (int l = 0; l < NL; l++) r9_row[NL*4 + l] = din[l];
    pulse_ld();
    #1;
    chk("R10 single write", drive_sel, exp_row(r9_row, 1'b0, 1'b0));

    // R7 load and strobe on the same clock
    cur_req = "R7";
    @(negedge clk); din = 4'hF; cp = 1'b0; load = 1'b0;
    @(negedge clk); cp = 1'b1; load = 1'b1;
    pulse_ld();
    #1;
    chk("R7 write dropped", drive_sel, exp_row(r9_row, 1'b0, 1'b0));

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule